// File: doc/BRIEF.md
# Companded-to-Linear PCM Expander

This block takes one 8-bit companded speech sample per transfer and turns it into a linear two's-complement word. Each sample carries its own law select, so mu-law and A-law traffic can be interleaved cycle by cycle. A mu-law sample expands to a 14-bit value that fills the whole output word. An A-law sample expands to a 13-bit value that sits in the upper thirteen bits, with the lowest bit held at zero. A per-sample inversion control undoes the line bit-inversion convention of each law before decoding. A format flag marks samples that are already linear, and these are passed through untouched.

Samples enter on a valid/ready stream and leave on a second valid/ready stream behind a single output register. An input is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The register loads whenever it is empty or its content is being taken in the same cycle, so `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While the output is stalled, the held word does not change and no new sample is taken. A sample that has been offered must stay on the inputs until it is accepted.

Top module: `pcm_expander`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `in_ready` is 1 until the first sample is accepted.
- R2: A sample accepted on a clock edge is presented with `out_valid` high directly after that edge, and results leave in the order they were accepted.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and on the next edge `out_valid` stays 1 with `out_data` unchanged.
- R4: When `in_is_log` is 0, `out_data` equals the 14-bit `in_data`, whatever the values of `in_law_a` and `in_invert`.
- R5: Mu-law expansion (`in_is_log`=1, `in_law_a`=0) is defined on the post-inversion byte w, where w[7] is the sign (1 = negative), w[6:4] is the segment e and w[3:0] is the mantissa m. The magnitude is ((2m+33) << e) - 33, and the signed result fills `out_data`[13:0]. A negative zero gives 0.
- R6: A-law expansion (`in_law_a`=1) is defined on the post-inversion byte w, where w[7]=1 means positive. The magnitude is 2m+1 for e=0 and (2m+33) << (e-1) otherwise. The signed 13-bit result is placed in `out_data`[13:1], and `out_data`[0] is 0.
- R7: With `in_invert`=1, w is the code XOR 0x55 for A-law and the code XOR 0xFF for mu-law. With `in_invert`=0, w is the code itself.
- R8: For companded samples only `in_data`[7:0] is used, and bits [13:8] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 14 | Linear word, or a companded code in bits [7:0] |
| in_is_log | input | 1 | 1 = companded code, 0 = already linear |
| in_law_a | input | 1 | 1 = A-law, 0 = mu-law |
| in_invert | input | 1 | 1 = undo line bit inversion before decoding |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 14 | Linear result |

## Verification
Every result is due on the edge that accepts its sample. The bench therefore checks `out_valid` at the next falling edge after each acceptance, and it compares the word at the falling edge where `out_valid` and `out_ready` are both high. Inputs and `out_ready` are driven just after a falling edge. Both handshakes are then evaluated a moment later, before the coming rising edge, so the expected-value queue is pushed and popped in the same cycles as the design. During a stall, the held word is recorded and compared one cycle later to show that it has not moved.

// File: rtl/pcm_expander_pkg.sv
package pcm_expander_pkg;
  localparam int LOG_W   = 8;   // companded code width
  localparam int LIN_W   = 14;  // output word width (mu-law linear)
  localparam int ALIN_W  = 13;  // A-law linear width
  localparam int SEG_W   = 3;
  localparam int MANT_W  = 4;
  localparam int BASE_W  = MANT_W + 2;
  localparam int MU_MAG_W = LIN_W - 1;
  localparam int A_MAG_W  = ALIN_W - 1;
  localparam logic [LOG_W-1:0] A_FLIP_MASK  = 8'h55;
  localparam logic [LOG_W-1:0] MU_FLIP_MASK = 8'hFF;
  localparam int MU_BIAS  = 33;
  localparam int MU_MAX_MAG = 8031;
  localparam int A_MAX_MAG  = 4032;
endpackage

// File: rtl/pcm_code_flip.sv
module pcm_code_flip
  import pcm_expander_pkg::*;
#(
  parameter logic [LOG_W-1:0] MASK = '1
) (
  input  logic             en_i,
  input  logic [LOG_W-1:0] code_i,
  output logic [LOG_W-1:0] code_o
);
  assign code_o = en_i ? (code_i ^ MASK) : code_i;
endmodule

// File: rtl/pcm_mulaw_expand.sv
module pcm_mulaw_expand
  import pcm_expander_pkg::*;
(
  input  logic [LOG_W-1:0] code_i,
  output logic [LIN_W-1:0] lin_o
);
  logic [SEG_W-1:0]    seg;
  logic [BASE_W-1:0]   base;
  logic [MU_MAG_W-1:0] mag;

  always_comb begin
    seg  = code_i[MANT_W +: SEG_W];
    base = {1'b1, code_i[MANT_W-1:0], 1'b1};
    mag  = ({{(MU_MAG_W-BASE_W){1'b0}}, base} << seg) - MU_MAG_W'(MU_BIAS);
    lin_o = code_i[LOG_W-1] ? (LIN_W'(0) - {1'b0, mag}) : {1'b0, mag};
    if (!$isunknown(code_i))
      assert_mu_range_R5: assert (mag <= MU_MAG_W'(MU_MAX_MAG))
        else $error("mu-law magnitude out of range");
  end
endmodule

// File: rtl/pcm_alaw_expand.sv
module pcm_alaw_expand
  import pcm_expander_pkg::*;
(
  input  logic [LOG_W-1:0] code_i,
  output logic [LIN_W-1:0] lin_o
);
  logic [SEG_W-1:0]   seg;
  logic [BASE_W-1:0]  base;
  logic [A_MAG_W-1:0] mag;
  logic [ALIN_W-1:0]  val;

  always_comb begin
    seg  = code_i[MANT_W +: SEG_W];
    base = {1'b1, code_i[MANT_W-1:0], 1'b1};
    if (seg == '0)
      mag = {{(A_MAG_W-MANT_W-1){1'b0}}, code_i[MANT_W-1:0], 1'b1};
    else
      mag = {{(A_MAG_W-BASE_W){1'b0}}, base} << (seg - SEG_W'(1));
    val   = code_i[LOG_W-1] ? {1'b0, mag} : (ALIN_W'(0) - {1'b0, mag});
    lin_o = {val, {(LIN_W-ALIN_W){1'b0}}};
    if (!$isunknown(code_i))
      assert_a_range_R6: assert (mag != '0 && mag <= A_MAG_W'(A_MAX_MAG))
        else $error("A-law magnitude out of range");
  end
endmodule

// File: rtl/pcm_expander.sv
module pcm_expander
  import pcm_expander_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LIN_W-1:0] in_data,
  input  logic             in_is_log,
  input  logic             in_law_a,
  input  logic             in_invert,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LIN_W-1:0] out_data
);
  localparam int NLAW = 2;
  localparam logic [LOG_W-1:0] MASKS [NLAW] = '{MU_FLIP_MASK, A_FLIP_MASK};

  logic [LOG_W-1:0] flipped [NLAW];
  logic [LIN_W-1:0] decoded [NLAW];
  logic [LIN_W-1:0] nxt_word;
  logic             valid_q;
  logic [LIN_W-1:0] data_q;
  logic             tag_a_q;

  for (genvar g = 0; g < NLAW; g++) begin : g_law
    pcm_code_flip #(.MASK(MASKS[g])) u_flip (
      .en_i  (in_invert),
      .code_i(in_data[LOG_W-1:0]),
      .code_o(flipped[g])
    );
    if (g == 0) begin : g_mu
      pcm_mulaw_expand u_dec (.code_i(flipped[g]), .lin_o(decoded[g]));
    end else begin : g_a
      pcm_alaw_expand u_dec (.code_i(flipped[g]), .lin_o(decoded[g]));
    end
  end

  always_comb begin
    if (!in_is_log)     nxt_word = in_data;
    else if (in_law_a)  nxt_word = decoded[1];
    else                nxt_word = decoded[0];
  end

  assign in_ready  = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      tag_a_q <= 1'b0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) begin
        data_q  <= nxt_word;
        tag_a_q <= in_is_log && in_law_a;
      end
    end
  end

  assert_accept_shows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid)
    else $error("accepted sample not presented");

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data))
    else $error("stalled output changed");

  assert_stall_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready)
    else $error("input taken during stall");

  assert_alaw_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && tag_a_q |-> out_data[0] == 1'b0)
    else $error("A-law result has nonzero lsb");
endmodule

// File: tb/pcm_expander_bench.sv
module pcm_expander_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 3000;
  localparam int QD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [13:0] in_data = '0;
  logic in_is_log = 1'b0;
  logic in_law_a = 1'b0;
  logic in_invert = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [13:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [13:0] exp_q [QD];
  string req_q [QD];
  int wr = 0;
  int rd = 0;
  string cur_req = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_expander u_pcm_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_is_log(in_is_log), .in_law_a(in_law_a),
    .in_invert(in_invert), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [13:0] ref_word(logic [13:0] d, bit is_log, bit law_a, bit inv);
    int w, e, m, mag, val;
    if (!is_log) return d;
    w = int'(d[7:0]);
    e = (w >> 4) & 7;
    m = w & 15;
    if (law_a) begin
      if (inv) w = w ^ 'h55;
      e = (w >> 4) & 7;
      m = w & 15;
      mag = (e == 0) ? (2*m + 1) : ((2*m + 33) << (e - 1));
      val = ((w & 'h80) != 0) ? mag : -mag;
      return {val[12:0], 1'b0};
    end
    if (inv) w = w ^ 'hFF;
    e = (w >> 4) & 7;
    m = w & 15;
    mag = ((2*m + 33) << e) - 33;
    val = ((w & 'h80) != 0) ? -mag : mag;
    return val[13:0];
  endfunction

  task automatic chk(string req, logic [13:0] act, logic [13:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    bit acc_prev;
    bit stall_prev;
    logic [13:0] stall_data;
    int k;
    int cyc;
    int phase;
    void'($urandom(32'd20240611));
    acc_prev = 0;
    stall_prev = 0;
    stall_data = '0;
    k = 0;
    cyc = 0;
    phase = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", {13'd0, out_valid}, 14'd0);
    chk("R1", {13'd0, in_ready}, 14'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {13'd0, out_valid}, 14'd0);
    chk("R1", {13'd0, in_ready}, 14'd1);

    while (phase < 3) begin
      @(negedge clk);
      if (acc_prev) chk("R2", {13'd0, out_valid}, 14'd1);
      if (stall_prev) begin
        chk("R3", {13'd0, out_valid}, 14'd1);
        chk("R3", out_data, stall_data);
      end
      // drive
      if (!(in_valid && !acc_prev)) begin
        if (phase == 0) begin
          // exhaustive: code, law, inversion; random upper bits (R8)
          in_valid  = 1'b1;
          in_is_log = 1'b1;
          in_data   = {6'($urandom), 8'(k)};
          in_law_a  = k[8];
          in_invert = k[9];
          cur_req   = k[9] ? "R7 R8" : (k[8] ? "R6 R8" : "R5 R8");
          k++;
          if (k == 1024) phase = 1;
        end else if (phase == 1) begin
          in_valid  = ($urandom % 4) != 0;
          in_is_log = ($urandom % 3) != 0;
          in_law_a  = $urandom % 2;
          in_invert = $urandom % 2;
          in_data   = 14'($urandom);
          if (cyc < 8) begin
            in_valid = 1'b1;
            in_is_log = 1'b0;
            in_data = (cyc % 2 == 0) ? 14'h3FFF : 14'h2001;
          end
          cur_req = !in_is_log ? "R4" : (in_invert ? "R7" : (in_law_a ? "R6" : "R5"));
        end else begin
          in_valid = 1'b0;
        end
      end
      if (phase == 0) out_ready = 1'b1;
      else if (phase == 1) out_ready = ($urandom % 3) != 0;
      else out_ready = 1'b1;
      #1;
      // output handshake at the coming edge
      if (out_valid && out_ready) begin
        if (wr == rd) begin
          n_cmp++; n_bad++;
          $display("FAIL R2 actual=extra expected=none");
        end else begin
          chk(req_q[rd % QD], out_data, exp_q[rd % QD]);
          rd++;
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      if (stall_prev) chk("R3", {13'd0, in_ready}, 14'd0);
      acc_prev = in_valid && in_ready;
      if (acc_prev) begin
        exp_q[wr % QD] = ref_word(in_data, in_is_log, in_law_a, in_invert);
        req_q[wr % QD] = cur_req;
        wr++;
      end
      if (phase == 1) begin
        cyc++;
        if (cyc >= N_RAND && !(in_valid && !acc_prev)) begin
          phase = 2;
          cyc = 0;
        end
      end else if (phase == 2) begin
        cyc++;
        if (cyc > 4) phase = 3;
      end
    end
    chk("R2", 14'(wr - rd), 14'd0);
    summary();
    $finish;
  end
endmodule